// File: doc/BRIEF.md
# Prioritised Interrupt Router

This block gathers level-sensitive interrupt lines from a set of sources and steers them to several targets. Each target stands for one hart running in one privilege mode. Software gives every source a small priority value and gives each target a private enable mask and a threshold. A target's request line rises whenever a source that is waiting, enabled for that target and ranked above the target's threshold exists.

The handler of a target reads its claim word to learn which source to serve. The read also withdraws that source from the waiting set. While the source is being served, its input is gated off. The handler ends service by writing the same source number back, which opens the gate again.

All state sits behind a 32-bit word-addressed register port with a fixed sparse layout. Reads are combinational in the cycle of the access. Writes and claim side effects take place at the clock edge that ends the access. Source number 0 is reserved and never stores anything.

Top module: `irq_router`

## Requirements
- R1: After reset every register reads 0, nothing is waiting, and all target request lines are low.
- R2: The priority of source N is a 3-bit value at byte offset 4*N, and the word reads back with bits 31:3 zero. The word at offset 0 (source 0) reads 0 and ignores writes.
- R3: The waiting bitmap is at offset 0x1000, with source N at bit N mod 32 of word N/32. A high input sets the bit at the next clock edge. The bit stays set after the input drops, until a claim. Writes to this region change nothing.
- R4: The enable mask of target C is at offset 0x2000 + 0x80*C, with source N at bit N mod 32 of word N/32. Bit 0 always reads 0.
- R5: The 3-bit threshold of target C is at offset 0x200000 + 0x1000*C. Target C's request line is high exactly when some source is waiting, enabled for C, and has a priority strictly above C's threshold.
- R6: A source with priority 0 never raises a request line and is never returned by a claim.
- R7: Reading the claim word at threshold offset + 4 returns the eligible source (as defined in R5) with the highest priority. On equal priority the lowest number wins. The read returns 0 when no source is eligible.
- R8: A claim clears the returned source's waiting bit. That source cannot become waiting again until its number is written to the claim word of a target that has it enabled. After that write the source can wait again, as long as its input is still high.
- R9: Writing to a claim word a source number that the target does not have enabled has no effect.
- R10: The other words of a target's 4 KiB region, any target region above the last target, misaligned addresses and unmapped offsets all read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIrq | input | NumSrc | Level interrupt inputs, bit N for source N (bit 0 unused) |
| regValid | input | 1 | Register access in this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 26 | Byte address of the access |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the access cycle |
| irqOut | output | NumCtx | Request line per target |

## Verification
The hardest state to reach is a source that is claimed while its input stays high. In that state the gate must hold the bit clear across claims from other targets and across a completion sent to a target where the source is disabled. It must re-arm only after a valid completion. The stimulus builds this state by holding several lines high at once with tied and untied priorities. It drains them through a chain of claims, then sends a completion to a target with an empty mask. Finally it completes on the right target and re-claims from a second target.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  // Which register family an access lands in
  typedef enum logic [2:0] {
    SelNone,
    SelPrio,
    SelPend,
    SelEn,
    SelThr,
    SelClaim
  } regSelE;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic       wr;
    logic       rd;
    regSelE     sel;
    logic [9:0] idx;   // source number or word number
    logic [13:0] ctx;  // target number
  } regStrobeT;

endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int NumSrc = 32,
  parameter int NumCtx = 4
) (
  input  logic        regValid,
  input  logic        regWrite,
  input  logic [25:0] regAddr,
  output regStrobeT   strb
);
  localparam int NumWords = (NumSrc + 31) / 32;

  logic [18:0] enOff;    // word offset inside the enable area
  logic [13:0] ctxNum;   // target number inside the target area

  always_comb begin
    strb   = '0;
    enOff  = regAddr[20:2] - 19'h800;
    ctxNum = regAddr[25:12] - 14'h200;
    if (regValid && regAddr[1:0] == 2'b00) begin
      strb.wr = regWrite;
      strb.rd = !regWrite;
      if (regAddr < 26'h1000) begin
        if (32'(regAddr[11:2]) < NumSrc) begin
          strb.sel = SelPrio;
          strb.idx = regAddr[11:2];
        end
      end else if (regAddr < 26'h2000) begin
        if (32'(regAddr[11:2]) < NumWords) begin
          strb.sel = SelPend;
          strb.idx = regAddr[11:2];
        end
      end else if (regAddr < 26'h200000) begin
        if (32'(enOff[18:5]) < NumCtx && 32'(enOff[4:0]) < NumWords) begin
          strb.sel = SelEn;
          strb.idx = {5'b0, enOff[4:0]};
          strb.ctx = enOff[18:5];
        end
      end else if (32'(ctxNum) < NumCtx && regAddr[11:3] == 9'd0) begin
        strb.sel = regAddr[2] ? SelClaim : SelThr;
        strb.ctx = ctxNum;
      end
    end
  end

endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int NumSrc = 32,
  parameter int NumCtx = 4,
  parameter int PrioW  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NumSrc-1:0] srcIrq,
  input  regStrobeT         strb,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NumCtx-1:0] irqOut
);
  localparam int IdW      = $clog2(NumSrc);
  localparam int NumWords = (NumSrc + 31) / 32;
  localparam int FlatW    = NumWords * 32;

  logic [PrioW-1:0]  prio [NumSrc];
  logic [NumSrc-1:0] pend;
  logic [NumSrc-1:0] busy;
  logic [NumSrc-1:0] en   [NumCtx];
  logic [PrioW-1:0]  thr  [NumCtx];
  logic [IdW-1:0]    win  [NumCtx];
  logic [FlatW-1:0]  enFlat [NumCtx];
  logic [FlatW-1:0]  pendFlat;

  logic           claimHit;
  logic [IdW-1:0] claimId;
  logic           complHit;
  logic [IdW-1:0] complId;

  assign pendFlat = FlatW'(pend);
  assign complId  = wdata[IdW-1:0];

  // Per-target arbiter: strict compare in ascending order keeps the lowest id on ties
  for (genvar c = 0; c < NumCtx; c++) begin : g_arb
    logic [PrioW-1:0] bestP;
    logic [IdW-1:0]   winC;
    always_comb begin
      bestP = thr[c];
      winC  = '0;
      for (int s = 1; s < NumSrc; s++) begin
        if (pend[s] && en[c][s] && prio[s] > bestP) begin
          bestP = prio[s];
          winC  = IdW'(s);
        end
      end
    end
    assign win[c]    = winC;
    assign irqOut[c] = (winC != '0);
    assign enFlat[c] = FlatW'(en[c]);

    p_win_above_thr_r5: assert property (@(posedge clk) disable iff (!rstN)
      irqOut[c] |-> (prio[winC] > thr[c]) && en[c][winC] && pend[winC]);
    p_zero_prio_silent_r6: assert property (@(posedge clk) disable iff (!rstN)
      irqOut[c] |-> prio[winC] != '0);
  end

  // Claim and completion targets
  always_comb begin
    claimId  = '0;
    complHit = 1'b0;
    for (int c = 0; c < NumCtx; c++) begin
      if (strb.ctx == 14'(c)) begin
        claimId  = win[c];
        complHit = strb.wr && strb.sel == SelClaim && wdata < 32'(NumSrc) &&
                   complId != '0 && en[c][complId];
      end
    end
  end
  assign claimHit = strb.rd && strb.sel == SelClaim && claimId != '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NumSrc; s++) prio[s] <= '0;
      for (int c = 0; c < NumCtx; c++) begin
        en[c]  <= '0;
        thr[c] <= '0;
      end
      pend <= '0;
      busy <= '0;
    end else begin
      for (int s = 1; s < NumSrc; s++) begin
        if (strb.wr && strb.sel == SelPrio && strb.idx == 10'(s))
          prio[s] <= wdata[PrioW-1:0];
      end
      for (int c = 0; c < NumCtx; c++) begin
        if (strb.wr && strb.sel == SelThr && strb.ctx == 14'(c))
          thr[c] <= wdata[PrioW-1:0];
        for (int s = 1; s < NumSrc; s++) begin
          if (strb.wr && strb.sel == SelEn && strb.ctx == 14'(c) && strb.idx == 10'(s / 32))
            en[c][s] <= wdata[s % 32];
        end
      end
      // Gateway: a claimed source stays gated until a valid completion
      for (int s = 1; s < NumSrc; s++) begin
        if (claimHit && claimId == IdW'(s)) begin
          pend[s] <= 1'b0;
          busy[s] <= 1'b1;
        end else begin
          if (complHit && complId == IdW'(s)) busy[s] <= 1'b0;
          if (srcIrq[s] && !busy[s]) pend[s] <= 1'b1;
        end
      end
    end
  end

  // Read mux
  always_comb begin
    rdata = '0;
    case (strb.sel)
      SelPrio:
        for (int s = 0; s < NumSrc; s++)
          if (strb.idx == 10'(s)) rdata = 32'(prio[s]);
      SelPend:
        for (int w = 0; w < NumWords; w++)
          if (strb.idx == 10'(w)) rdata = pendFlat[w*32 +: 32];
      SelEn:
        for (int c = 0; c < NumCtx; c++)
          for (int w = 0; w < NumWords; w++)
            if (strb.ctx == 14'(c) && strb.idx == 10'(w)) rdata = enFlat[c][w*32 +: 32];
      SelThr:
        for (int c = 0; c < NumCtx; c++)
          if (strb.ctx == 14'(c)) rdata = 32'(thr[c]);
      SelClaim:
        if (strb.rd) rdata = 32'(claimId);
      default: rdata = '0;
    endcase
  end

  p_claim_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    claimHit |=> !pend[$past(claimId)]);

  for (genvar s = 1; s < NumSrc; s++) begin : g_gate_chk
    p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
      busy[s] |-> !pend[s]);
  end

  p_no_stray_complete_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wr && strb.sel == SelClaim && !complHit) |=> ($past(busy) & ~busy) == '0);

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NumSrc = 32,
  parameter int NumCtx = 4,
  parameter int PrioW  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NumSrc-1:0] srcIrq,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [25:0]       regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic [NumCtx-1:0] irqOut
);
  regStrobeT strb;

  irq_router_ctrl #(.NumSrc(NumSrc), .NumCtx(NumCtx)) u_ctrl (
    .regValid(regValid),
    .regWrite(regWrite),
    .regAddr (regAddr),
    .strb    (strb)
  );

  irq_router_dp #(.NumSrc(NumSrc), .NumCtx(NumCtx), .PrioW(PrioW)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .srcIrq(srcIrq),
    .strb  (strb),
    .wdata (regWdata),
    .rdata (regRdata),
    .irqOut(irqOut)
  );

endmodule

// File: tb/sim_irq_router.sv
module sim_irq_router;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIrq = '0;
  logic        regValid = 1'b0;
  logic        regWrite = 1'b0;
  logic [25:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [3:0]  irqOut;

  int nChk = 0;
  int nBad = 0;

  always #4 clk = ~clk;

  irq_router u0 (
    .clk(clk), .rstN(rstN), .srcIrq(srcIrq), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input logic [25:0] a, input logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic rdReg(input logic [25:0] a, output logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regValid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irqOut", 32'(irqOut), 32'h0);
    rdReg(26'h14, v);      check("R1 prio5", v, 0);
    rdReg(26'h1000, v);    check("R1 pending", v, 0);
    rdReg(26'h2000, v);    check("R1 enable ctx0", v, 0);
    rdReg(26'h201000, v);  check("R1 thr ctx1", v, 0);
  endtask

  task automatic t_prio();
    logic [31:0] v;
    wrReg(26'h14, 32'hFFFF_FFFF);
    rdReg(26'h14, v);      check("R2 prio5 width", v, 32'h7);
    wrReg(26'h0, 32'h5);
    rdReg(26'h0, v);       check("R2 source0 word", v, 0);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    wrReg(26'h2080, 32'hFFFF_FFFF);
    rdReg(26'h2080, v);    check("R4 ctx1 mask bit0", v, 32'hFFFF_FFFE);
    rdReg(26'h2000, v);    check("R4 ctx0 untouched", v, 0);
  endtask

  task automatic t_pending();
    logic [31:0] v;
    srcIrq[3] = 1'b1;
    tick(1);
    rdReg(26'h1000, v);    check("R3 latched", v, 32'h8);
    wrReg(26'h1000, 32'h0);
    rdReg(26'h1000, v);    check("R3 write ignored", v, 32'h8);
    srcIrq[3] = 1'b0;
    tick(2);
    rdReg(26'h1000, v);    check("R3 held after drop", v, 32'h8);
    check("R6 prio0 no request", 32'(irqOut), 32'h0);
  endtask

  task automatic t_prio0();
    logic [31:0] v;
    srcIrq[9] = 1'b1;
    wrReg(26'h2000, 32'h200);
    check("R6 irq0 low", 32'(irqOut[0]), 0);
    rdReg(26'h200004, v);  check("R6 claim none", v, 0);
    rdReg(26'h1000, v);    check("R6 still waiting", v, 32'h208);
  endtask

  task automatic t_threshold();
    wrReg(26'hC, 32'h2);
    wrReg(26'h2000, 32'h208);
    wrReg(26'h200000, 32'h2);
    check("R5 equal to thr", 32'(irqOut[0]), 0);
    wrReg(26'h200000, 32'h1);
    check("R5 above thr", 32'(irqOut[0]), 1);
    check("R5 ctx1", 32'(irqOut[1]), 1);
    wrReg(26'h200000, 32'h0);
  endtask

  task automatic t_arbit();
    logic [31:0] v;
    wrReg(26'h14, 32'h4);
    wrReg(26'h18, 32'h4);
    wrReg(26'h1C, 32'h1);
    srcIrq[7:5] = 3'b111;
    wrReg(26'h2000, 32'h2E8);
    rdReg(26'h200004, v);  check("R7 tie lowest id", v, 5);
    rdReg(26'h200004, v);  check("R7 second of tie", v, 6);
    rdReg(26'h200004, v);  check("R7 mid prio", v, 3);
    rdReg(26'h200004, v);  check("R7 low prio", v, 7);
    rdReg(26'h200004, v);  check("R7 empty", v, 0);
    rdReg(26'h1000, v);    check("R8 gated while high", v, 32'h200);
    check("R8 irq0 drained", 32'(irqOut[0]), 0);
  endtask

  task automatic t_complete();
    logic [31:0] v;
    wrReg(26'h202004, 32'h6);
    tick(2);
    rdReg(26'h1000, v);    check("R9 disabled target", v, 32'h200);
    wrReg(26'h200004, 32'h6);
    tick(1);
    rdReg(26'h1000, v);    check("R8 re-armed", v, 32'h240);
    rdReg(26'h201004, v);  check("R8 claim on ctx1", v, 6);
    rdReg(26'h1000, v);    check("R8 cleared again", v, 32'h200);
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    wrReg(26'h200000, 32'h3);
    wrReg(26'h200008, 32'hFF);
    rdReg(26'h200008, v);  check("R10 reserved word", v, 0);
    rdReg(26'h200000, v);  check("R10 thr kept", v, 3);
    wrReg(26'h204000, 32'h5);
    rdReg(26'h204000, v);  check("R10 missing target", v, 0);
    rdReg(26'h15, v);      check("R10 misaligned", v, 0);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    t_reset();
    t_prio();
    t_enable();
    t_pending();
    t_prio0();
    t_threshold();
    t_arbit();
    t_complete();
    t_reserved();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule